// File: doc/BRIEF.md
# Streaming Read Prefetch FIFO

This block sits between a processor core and a banked shared memory and turns a single start command into a steady stream of sequential read data. The core gives a byte address. From then on the block fetches consecutive 32-bit words from memory in fixed bursts, keeps them in a small circular store and hands out bytes, halfwords or words when the core pops. A start may be blocking, in which case a busy output stays high until the first word has landed, or non-blocking, in which case the core carries on at once and any pop made too early returns zero with its valid flag low.

A new start empties the store in the cycle it is issued, so stale bytes never reach the core. If a burst for the previous stream is still returning, its remaining words are counted off and dropped before the next request goes out. Refills are issued only when a whole burst fits, and fetching goes on until the store is full.

The fetch side is one state machine. F_OFF holds after reset until the first start. F_HOLD waits for room for a burst and moves to F_ASK when the store can take one. F_ASK drives the memory request and moves to F_TAKE on a grant. F_TAKE writes each returned word and goes back to F_HOLD after the last one. F_FLUSH drops the returned words of a burst that was cut off by a restart and goes to F_HOLD when the last one has arrived. A start moves the machine from F_OFF, F_HOLD or F_ASK to F_ASK, and from F_TAKE or F_FLUSH to F_FLUSH unless that cycle's returned word was the last one outstanding, in which case it goes to F_ASK.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, busy and mem_req are low, and a pop returns pop_data 0 with pop_valid low.
- R2: A start empties the store in the cycle it is issued. A pop in that cycle, or before the new stream's first word has arrived, returns 0 with pop_valid low. Data left over from the earlier stream never appears.
- R3: The store holds up to 19 words, and all 19 can be popped back in order.
- R4: A request is raised only while at least 6 slots are free. Each grant returns 6 consecutive words, the first at word address start_addr[15:2] and each later burst directly after the one before it.
- R5: With no pops after a start, fetching goes on until exactly 3 bursts (18 words) are stored. One more burst is requested once 6 slots are free again.
- R6: pop_size 0 pops a byte, 1 a halfword and 2 or 3 a word. Data is right-aligned and little-endian, with the lowest address in bits 7:0. The byte pointer advances by 1, 2 or 4.
- R7: The low two bits of start_addr select the first byte within the first fetched word.
- R8: A halfword or word pop that runs into the next stored word returns 0, leaves pop_valid low and does not advance until that next word is present.
- R9: A non-blocking start (start_block=0) never raises busy. A pop made before data is present returns 0 with pop_valid low.
- R10: A blocking start (start_block=1) raises busy in its own cycle. Busy stays high until the first word is stored, and a pop is valid as soon as busy has fallen.
- R11: A start made while a burst is outstanding discards that burst's remaining words. No new request is raised until all of them have returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start or restart the stream this cycle |
| start_block | input | 1 | 1 = blocking start, 0 = non-blocking |
| start_addr | input | ADDR_W | Byte address of the first byte of the stream |
| busy | output | 1 | A blocking start is waiting for its first word |
| pop_req | input | 1 | Pop request |
| pop_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| pop_data | output | 32 | Popped data, right-aligned, 0 when not valid |
| pop_valid | output | 1 | pop_data holds real stream data |
| mem_req | output | 1 | Burst read request toward the slice arbiter |
| mem_addr | output | ADDR_W-2 | Word address of the first word of the burst |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | One returned word is on mem_rdata |
| mem_rdata | input | 32 | Returned word |

## Verification
The assertions assume that memory returns exactly 6 words per grant and never returns a word with no burst outstanding. The bench's memory model meets this by granting only while mem_req is high and by replaying exactly one burst counter per grant, with a programmable latency and spacing. The assertions also assume that a blocking start is answered by the core holding off pops. The blocking scenario pops only after busy has fallen, and every other early pop follows a non-blocking start.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;

    typedef enum logic [2:0] {
        F_OFF,
        F_HOLD,
        F_ASK,
        F_TAKE,
        F_FLUSH
    } fetch_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/spf_store.sv
`timescale 1ns/1ps
module spf_store #(
    parameter int DEPTH = 19,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             rd_adv,
    output logic [31:0]      word0,
    output logic [31:0]      word1,
    output logic [CNT_W-1:0] count
);

    logic [31:0]      slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_adv) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_adv);
        end
    end

    assign word0 = slots[rd_ptr];
    assign word1 = slots[bump(rd_ptr)];

endmodule

// File: rtl/spf_extract.sv
`timescale 1ns/1ps
module spf_extract
    import spf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [31:0]      word0,
    input  logic [31:0]      word1,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       boff,
    input  logic             pop_req,
    input  logic [1:0]       pop_size,
    input  logic             blocked,
    output logic [31:0]      data,
    output logic             valid,
    output logic             consumed,
    output logic [1:0]       boff_next
);

    logic [2:0]  nbytes;
    logic [3:0]  span;
    logic        need_two;
    logic        have;
    logic [63:0] wide;
    logic [31:0] picked;

    always_comb begin
        nbytes   = size_bytes(pop_size);
        span     = {2'b00, boff} + {1'b0, nbytes};
        need_two = span > 4'd4;
        have     = need_two ? (count >= CNT_W'(2)) : (count >= CNT_W'(1));
        valid    = pop_req && !blocked && have;
        wide     = {word1, word0} >> {boff, 3'b000};
        case (nbytes)
            3'd1:    picked = {24'h0, wide[7:0]};
            3'd2:    picked = {16'h0, wide[15:0]};
            default: picked = wide[31:0];
        endcase
        data      = valid ? picked : 32'h0;
        consumed  = valid && (span >= 4'd4);
        boff_next = span[1:0];
    end

endmodule

// File: rtl/spf_fetch.sv
`timescale 1ns/1ps
module spf_fetch
    import spf_pkg::*;
#(
    parameter int DEPTH   = 19,
    parameter int BURST   = 6,
    parameter int WADDR_W = 14,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEFT_W = $clog2(BURST + 1),
    localparam int ROOM_MAX = DEPTH - BURST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic [WADDR_W-1:0] start_word,
    input  logic [CNT_W-1:0]   count,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               wr_en,
    output logic [31:0]        wr_data
);

    fetch_state_t       state_q, state_d;
    logic [LEFT_W-1:0]  left_q, left_d, left_after;
    logic [WADDR_W-1:0] addr_q, addr_d;
    logic               rv_take, room, in_burst;

    always_comb begin
        state_d    = state_q;
        left_d     = left_q;
        addr_d     = addr_q;
        in_burst   = (state_q == F_TAKE) || (state_q == F_FLUSH);
        rv_take    = mem_rvalid && in_burst;
        left_after = left_q - LEFT_W'(rv_take);
        room       = count <= CNT_W'(ROOM_MAX);
        unique case (state_q)
            F_OFF:  ;
            F_HOLD: if (room) state_d = F_ASK;
            F_ASK:  if (mem_req && mem_gnt) begin
                        state_d = F_TAKE;
                        left_d  = LEFT_W'(BURST);
                        addr_d  = addr_q + WADDR_W'(BURST);
                    end
            F_TAKE, F_FLUSH: begin
                        left_d = left_after;
                        if (left_after == '0) state_d = F_HOLD;
                    end
        endcase
        if (start_valid) begin
            addr_d = start_word;
            if (in_burst && left_after != '0) begin
                state_d = F_FLUSH;
                left_d  = left_after;
            end else begin
                state_d = F_ASK;
                left_d  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_OFF;
            left_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        mem_req  = (state_q == F_ASK) && !start_valid;
        mem_addr = addr_q;
        wr_en    = (state_q == F_TAKE) && mem_rvalid && !start_valid;
        wr_data  = mem_rdata;
    end

endmodule

// File: rtl/stream_prefetch.sv
`timescale 1ns/1ps
module stream_prefetch #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 19,
    parameter int BURST  = 6,
    localparam int WADDR_W = ADDR_W - 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic               start_block,
    input  logic [ADDR_W-1:0]  start_addr,
    output logic               busy,
    input  logic               pop_req,
    input  logic [1:0]         pop_size,
    output logic [31:0]        pop_data,
    output logic               pop_valid,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata
);

    logic [31:0]      word0, word1, wr_data;
    logic [CNT_W-1:0] occ;
    logic             wr_en, consumed, wait_q;
    logic [1:0]       boff_q, boff_next;

    spf_fetch #(.DEPTH(DEPTH), .BURST(BURST), .WADDR_W(WADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_word(start_addr[ADDR_W-1:2]),
        .count(occ),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    spf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(start_valid),
        .wr_en(wr_en), .wr_data(wr_data), .rd_adv(consumed),
        .word0(word0), .word1(word1), .count(occ)
    );

    spf_extract #(.CNT_W(CNT_W)) u_extract (
        .word0(word0), .word1(word1), .count(occ), .boff(boff_q),
        .pop_req(pop_req), .pop_size(pop_size), .blocked(start_valid),
        .data(pop_data), .valid(pop_valid),
        .consumed(consumed), .boff_next(boff_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boff_q <= 2'd0;
            wait_q <= 1'b0;
        end else if (start_valid) begin
            boff_q <= start_addr[1:0];
            wait_q <= start_block;
        end else begin
            if (pop_valid) boff_q <= boff_next;
            if (occ != '0) wait_q <= 1'b0;
        end
    end

    assign busy = (start_valid && start_block) || (wait_q && occ == '0);

endmodule

// File: rtl/spf_checker.sv
`timescale 1ns/1ps
module spf_checker #(
    parameter int DEPTH = 19,
    parameter int BURST = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_valid,
    input logic             start_block,
    input logic             busy,
    input logic             pop_req,
    input logic             pop_valid,
    input logic [31:0]      pop_data,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_rvalid,
    input logic [CNT_W-1:0] occupancy
);

    logic [7:0] outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else outstanding <= outstanding + ((mem_req && mem_gnt) ? 8'(BURST) : 8'd0)
                                        - (mem_rvalid ? 8'd1 : 8'd0);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));
    p_req_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> occupancy <= CNT_W'(DEPTH - BURST));
    p_start_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> occupancy == '0);
    p_start_pop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> !pop_valid);
    p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> pop_data == 32'h0);
    p_valid_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> pop_req);
    p_block_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_block) |-> busy);
    p_busy_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_valid) |-> occupancy == '0);
    p_one_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> outstanding == '0);
    p_resp_expected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> outstanding != '0);

endmodule

bind stream_prefetch spf_checker #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_block(start_block),
    .busy(busy), .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .occupancy(occ)
);

// File: tb/stream_prefetch_test.sv
`timescale 1ns/1ps
module stream_prefetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0, start_block = 1'b0;
    logic [15:0] start_addr = '0;
    logic        busy;
    logic        pop_req = 1'b0;
    logic [1:0]  pop_size = 2'd0;
    logic [31:0] pop_data;
    logic        pop_valid;
    logic        mem_req;
    logic [13:0] mem_addr;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int nchk = 0, nerr = 0;
    int lat = 2, gap = 0;
    int grants = 0, overlap = 0;
    int first_gaddr = -1;

    stream_prefetch uut (.*);

    always #4 clk = ~clk;   // 8 ns period

    function automatic logic [7:0] bval(input int b);
        logic [7:0] lo, hi;
        lo = b[7:0];
        hi = b[15:8];
        return lo + hi * 8'd17 + 8'h29;
    endfunction

    function automatic logic [31:0] exp_at(input int a, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'h0, bval(a)};
            2'd1:    return {16'h0, bval(a + 1), bval(a)};
            default: return {bval(a + 3), bval(a + 2), bval(a + 1), bval(a)};
        endcase
    endfunction

    // memory model: one burst of 6 words per grant
    initial begin
        int pend_n, paddr, wait_c, gaddr;
        bit granted;
        pend_n = 0; paddr = 0; wait_c = 0; gaddr = 0; granted = 0;
        forever begin
            @(negedge clk); #1;
            if (granted) begin
                pend_n = 6; paddr = gaddr; wait_c = lat;
            end
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
            if (pend_n > 0) begin
                if (wait_c > 0) wait_c--;
                else begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = exp_at(paddr * 4, 2'd2);
                    paddr++; pend_n--; wait_c = gap;
                end
            end
            if (mem_req && pend_n > 0) overlap++;
            granted = mem_req && rst_n;
            mem_gnt = granted;
            gaddr   = int'(mem_addr);
            if (granted) begin
                grants++;
                if (first_gaddr < 0) first_gaddr = gaddr;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic pop_once(input logic [1:0] sz, output logic [31:0] d, output logic v);
        @(negedge clk);
        pop_req = 1'b1; pop_size = sz;
        #2; d = pop_data; v = pop_valid;
        @(posedge clk); #1; pop_req = 1'b0;
    endtask

    task automatic check_pop(input logic [1:0] sz, input int a, input string tag);
        logic [31:0] d; logic v;
        pop_once(sz, d, v);
        check(v && d == exp_at(a, sz), tag, d, exp_at(a, sz));
    endtask

    task automatic check_pop_zero(input logic [1:0] sz, input string tag);
        logic [31:0] d; logic v;
        pop_once(sz, d, v);
        check(!v && d == 32'h0, tag, {d[30:0], v}, 32'h0);
    endtask

    task automatic do_start(input int a, input bit blk);
        @(negedge clk);
        start_valid = 1'b1; start_addr = 16'(a); start_block = blk;
        @(posedge clk); #1; start_valid = 1'b0; start_block = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rvalid();
        do begin @(negedge clk); #2; end while (!mem_rvalid);
    endtask

    task automatic t_reset();
        #2;
        check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
        check_pop_zero(2'd2, "R1 pop after reset");
    endtask

    task automatic t_nonblocking();
        lat = 3; gap = 0; first_gaddr = -1;
        @(negedge clk);
        start_valid = 1'b1; start_addr = 16'h0100; start_block = 1'b0;
        #2;
        check(busy == 1'b0, "R9 no busy on non-blocking start", 32'(busy), 0);
        @(posedge clk); #1; start_valid = 1'b0;
        check_pop_zero(2'd0, "R9 early pop returns zero");
        idle(40);
        check(first_gaddr == 32'h40, "R4 first burst word address", 32'(first_gaddr), 32'h40);
        check_pop(2'd0, 32'h100, "R6 byte pop");
        check_pop(2'd1, 32'h101, "R6 halfword pop");
        check_pop(2'd2, 32'h103, "R6 word pop");
        check_pop(2'd3, 32'h107, "R6 size code 3 pops a word");
        check_pop(2'd0, 32'h10B, "R6 byte after word");
    endtask

    task automatic t_offset();
        lat = 2; gap = 0;
        do_start(32'h0203, 1'b0);
        idle(30);
        check_pop(2'd1, 32'h203, "R7 offset 3 halfword");
        check_pop(2'd2, 32'h205, "R7 word after offset");
    endtask

    task automatic t_fill();
        int g0;
        lat = 2; gap = 0;
        idle(20);
        g0 = grants;
        do_start(32'h0400, 1'b0);
        idle(80);
        check(grants - g0 == 3, "R5 three bursts until full", 32'(grants - g0), 3);
        for (int i = 0; i < 4; i++) check_pop(2'd2, 32'h400 + 4 * i, "R4 word pop before refill");
        idle(10);
        check(grants - g0 == 3, "R4 no request with 5 free", 32'(grants - g0), 3);
        check_pop(2'd2, 32'h410, "R4 fifth word pop");
        idle(20);
        check(grants - g0 == 4, "R4 refill at 6 free", 32'(grants - g0), 4);
        for (int i = 0; i < 19; i++) check_pop(2'd2, 32'h414 + 4 * i, "R3 nineteen words in order");
    endtask

    task automatic t_restart();
        logic [31:0] d; logic v;
        idle(40);
        @(negedge clk);
        start_valid = 1'b1; start_addr = 16'h0800; start_block = 1'b0;
        pop_req = 1'b1; pop_size = 2'd2;
        #2; d = pop_data; v = pop_valid;
        check(!v && d == 0, "R2 pop in start cycle", d, 0);
        @(posedge clk); #1; start_valid = 1'b0; pop_req = 1'b0;
        check_pop_zero(2'd2, "R2 pop right after start");
        idle(30);
        check_pop(2'd2, 32'h800, "R2 new stream data");
    endtask

    task automatic t_cut_burst();
        int o0;
        o0 = overlap;
        lat = 1; gap = 3;
        do_start(32'h0900, 1'b0);
        wait_rvalid();
        do_start(32'h0C00, 1'b0);
        idle(70);
        check(overlap == o0, "R11 no request while words outstanding", 32'(overlap - o0), 0);
        check_pop(2'd2, 32'hC00, "R11 first word from new stream");
        check_pop(2'd2, 32'hC04, "R11 second word from new stream");
    endtask

    task automatic t_straddle();
        lat = 1; gap = 6;
        idle(80);
        do_start(32'h0E03, 1'b0);
        wait_rvalid();
        check_pop_zero(2'd2, "R8 straddling word waits");
        wait_rvalid();
        idle(1);
        check_pop(2'd2, 32'hE03, "R8 straddling word after second word");
    endtask

    task automatic t_blocking();
        int cyc;
        logic [31:0] d; logic v;
        lat = 4; gap = 0;
        idle(80);
        @(negedge clk);
        start_valid = 1'b1; start_addr = 16'h1000; start_block = 1'b1;
        #2;
        check(busy == 1'b1, "R10 busy in start cycle", 32'(busy), 1);
        @(posedge clk); #1; start_valid = 1'b0; start_block = 1'b0;
        cyc = 0;
        while (busy && cyc < 50) begin @(negedge clk); #2; cyc++; end
        check(busy == 1'b0 && cyc >= 3, "R10 busy held until first word", 32'(cyc), 3);
        pop_req = 1'b1; pop_size = 2'd0;
        #1; d = pop_data; v = pop_valid;
        @(posedge clk); #1; pop_req = 1'b0;
        check(v && d == exp_at(32'h1000, 2'd0), "R10 pop valid once busy falls", d, exp_at(32'h1000, 2'd0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nonblocking();
        t_offset();
        t_fill();
        t_restart();
        t_cut_burst();
        t_straddle();
        t_blocking();
        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule